// File: doc/BRIEF.md
# Masked Vector Broadcast Unit

This unit replicates a scalar taken from a 64-bit general-purpose register into every element of a vector destination. The element size can be 8, 16, 32 or 64 bits. The active vector length can be 128, 256 or 512 bits. Each element is governed by one bit of a writemask. A cleared mask bit either keeps the old destination element (merging) or clears it (zeroing). Every bit above the active length is always cleared.

The caller supplies:
- the old destination value;
- the mask value of the selected mask register and its index (index 0 means no masking);
- a 4-bit spare register-specifier field that must read all ones;
- a flag that says whether the machine is in 64-bit mode.

A legal request yields a registered 512-bit result one cycle later. An illegal request raises a one-cycle undefined-instruction fault and leaves the result register untouched.

Top module: `vbcast_unit`

## Requirements
- R1: Element size comes from `grain_sel` (00 = 8-bit, 01 = 16-bit, 1x = 32-bit, or 64-bit when `wide_sel` and `long_mode` are both 1). Each written element holds the low bits of `scalar_in` at that size.
- R2: `vlen_sel` selects the active length (00 = 128, 01 = 256, 10 = 512 bits). The element count is the active length divided by the element size.
- R3: All result bits from the active length up to bit 511 are zero, in every masking mode.
- R4: Element j is written with the broadcast value when `mask_bits[j]` is 1. When `mask_idx` is 0, every active element is written whatever `mask_bits` holds.
- R5: With `zero_mode` = 0 (merging), an active element whose mask bit is 0 takes its value from `old_dest`.
- R6: With `zero_mode` = 1 (zeroing), an active element whose mask bit is 0 becomes zero.
- R7: Only the low element-count bits of `mask_bits` are used. Higher bits have no effect on the result.
- R8: With `long_mode` = 0, `wide_sel` is ignored and the 32-bit element size is used.
- R9: When `spare_field` is not 4'b1111, `ud_fault` is 1 for one cycle, `res_valid` stays 0, and `res_data` keeps its previous value.
- R10: `vlen_sel` = 11 is reserved. It raises `ud_fault` with the same effects as R9.
- R11: After reset, `res_valid` and `ud_fault` are 0 and `res_data` is zero. A legal request raises `res_valid` exactly one cycle later. Without `in_valid`, neither flag rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| scalar_in | input | 64 | Scalar source register |
| grain_sel | input | 2 | Element size code |
| wide_sel | input | 1 | Selects 64-bit elements within the 32-bit family |
| long_mode | input | 1 | Machine is in 64-bit mode |
| vlen_sel | input | 2 | Active vector length code |
| mask_idx | input | 3 | Selected mask register, 0 = no masking |
| mask_bits | input | 64 | Value of the selected mask register |
| zero_mode | input | 1 | 1 = zeroing, 0 = merging |
| spare_field | input | 4 | Reserved specifier, must be 1111 |
| old_dest | input | 512 | Previous destination value |
| res_valid | output | 1 | Result is valid |
| res_data | output | 512 | Result register |
| ud_fault | output | 1 | Undefined-instruction fault |

## Verification
Every result, whether data, valid or fault, is registered once, so it is due one clock edge after the request is sampled. The bench drives each request on a falling edge and drops `in_valid` on the next falling edge. It then compares outputs at that point, between the registering edge and the following one. For faulting requests, the register value captured before the request serves as the expected data. The bench also checks that `res_valid` is 0 on the following idle cycle.

// File: rtl/vbcast_pkg.sv
package vbcast_pkg;
    parameter int SCALAR_W = 64;
    parameter int VEC_W    = 512;
    parameter int MASK_W   = 64;
    parameter int SPARE_W  = 4;
    parameter int MIN_VL_BYTES = 16;
    localparam int VEC_BYTES    = VEC_W / 8;
    localparam int SCALAR_BYTES = SCALAR_W / 8;
    localparam int BIDX_W       = $clog2(VEC_BYTES);

    typedef enum logic [1:0] {
        ESZ_8  = 2'd0,
        ESZ_16 = 2'd1,
        ESZ_32 = 2'd2,
        ESZ_64 = 2'd3
    } esize_e;

    typedef enum logic [1:0] {
        VL_128 = 2'd0,
        VL_256 = 2'd1,
        VL_512 = 2'd2,
        VL_RSV = 2'd3
    } vlen_e;

    typedef struct packed {
        logic             valid;
        logic             fault;
        logic [VEC_W-1:0] data;
    } bc_state_t;
endpackage

// File: rtl/vbcast_decode.sv
module vbcast_decode
    import vbcast_pkg::*;
#(
    parameter int SPW = SPARE_W
) (
    input  logic [1:0]     grain_sel,
    input  logic           wide_sel,
    input  logic           long_mode,
    input  logic [1:0]     vlen_sel,
    input  logic [SPW-1:0] spare_field,
    output esize_e         esize,
    output vlen_e          vlen,
    output logic           bad_req
);
    always_comb begin
        unique case (grain_sel)
            2'b00:   esize = ESZ_8;
            2'b01:   esize = ESZ_16;
            default: esize = (wide_sel && long_mode) ? ESZ_64 : ESZ_32;
        endcase
        vlen    = vlen_e'(vlen_sel);
        bad_req = (spare_field != {SPW{1'b1}}) || (vlen == VL_RSV);
    end
endmodule

// File: rtl/vbcast_replicate.sv
module vbcast_replicate
    import vbcast_pkg::*;
#(
    parameter int SW = SCALAR_W,
    parameter int VW = VEC_W
) (
    input  logic [SW-1:0] scalar_in,
    input  esize_e        esize,
    output logic [VW-1:0] bcast
);
    localparam int NB = VW / 8;
    localparam int SB = SW / 8;
    localparam int SI_W = $clog2(SB);

    for (genvar b = 0; b < NB; b++) begin : g_byte
        logic [SI_W-1:0] src_idx;
        always_comb begin
            unique case (esize)
                ESZ_8:   src_idx = '0;
                ESZ_16:  src_idx = SI_W'(b % 2);
                ESZ_32:  src_idx = SI_W'(b % 4);
                default: src_idx = SI_W'(b % 8);
            endcase
            bcast[b*8 +: 8] = scalar_in[src_idx*8 +: 8];
        end
    end
endmodule

// File: rtl/vbcast_lane_ctrl.sv
module vbcast_lane_ctrl
    import vbcast_pkg::*;
#(
    parameter int VW = VEC_W,
    parameter int MW = MASK_W
) (
    input  esize_e          esize,
    input  vlen_e           vlen,
    input  logic            no_mask,
    input  logic [MW-1:0]   mask_bits,
    output logic [VW/8-1:0] wr_en,
    output logic [VW/8-1:0] live
);
    localparam int NB = VW / 8;
    localparam int IW = $clog2(NB);

    logic [IW:0] live_bytes;

    always_comb begin
        unique case (vlen)
            VL_128:  live_bytes = (IW+1)'(MIN_VL_BYTES);
            VL_256:  live_bytes = (IW+1)'(MIN_VL_BYTES * 2);
            default: live_bytes = (IW+1)'(MIN_VL_BYTES * 4);
        endcase
    end

    for (genvar b = 0; b < NB; b++) begin : g_lane
        logic [IW-1:0] elem;
        always_comb begin
            elem     = IW'(b) >> esize;
            live[b]  = (IW+1)'(b) < live_bytes;
            wr_en[b] = no_mask || mask_bits[elem];
        end
    end
endmodule

// File: rtl/vbcast_unit.sv
module vbcast_unit
    import vbcast_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [SCALAR_W-1:0] scalar_in,
    input  logic [1:0]         grain_sel,
    input  logic               wide_sel,
    input  logic               long_mode,
    input  logic [1:0]         vlen_sel,
    input  logic [2:0]         mask_idx,
    input  logic [MASK_W-1:0]  mask_bits,
    input  logic               zero_mode,
    input  logic [SPARE_W-1:0] spare_field,
    input  logic [VEC_W-1:0]   old_dest,
    output logic               res_valid,
    output logic [VEC_W-1:0]   res_data,
    output logic               ud_fault
);
    esize_e               esize;
    vlen_e                vlen;
    logic                 bad_req;
    logic [VEC_W-1:0]     bcast;
    logic [VEC_BYTES-1:0] wr_en;
    logic [VEC_BYTES-1:0] live;
    bc_state_t            st_d, st_q;

    vbcast_decode u_decode (
        .grain_sel   (grain_sel),
        .wide_sel    (wide_sel),
        .long_mode   (long_mode),
        .vlen_sel    (vlen_sel),
        .spare_field (spare_field),
        .esize       (esize),
        .vlen        (vlen),
        .bad_req     (bad_req)
    );

    vbcast_replicate u_repl (
        .scalar_in (scalar_in),
        .esize     (esize),
        .bcast     (bcast)
    );

    vbcast_lane_ctrl u_lanes (
        .esize     (esize),
        .vlen      (vlen),
        .no_mask   (mask_idx == 3'd0),
        .mask_bits (mask_bits),
        .wr_en     (wr_en),
        .live      (live)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        st_d.fault = 1'b0;
        if (in_valid) begin
            if (bad_req) begin
                st_d.fault = 1'b1;
            end else begin
                st_d.valid = 1'b1;
                for (int b = 0; b < VEC_BYTES; b++) begin
                    if (!live[b])
                        st_d.data[b*8 +: 8] = 8'h00;
                    else if (wr_en[b])
                        st_d.data[b*8 +: 8] = bcast[b*8 +: 8];
                    else if (zero_mode)
                        st_d.data[b*8 +: 8] = 8'h00;
                    else
                        st_d.data[b*8 +: 8] = old_dest[b*8 +: 8];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res_valid = st_q.valid;
    assign ud_fault  = st_q.fault;
    assign res_data  = st_q.data;
endmodule

// File: rtl/vbcast_unit_chk.sv
module vbcast_unit_chk
    import vbcast_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic [1:0]         vlen_sel,
    input logic [2:0]         mask_idx,
    input logic [MASK_W-1:0]  mask_bits,
    input logic               zero_mode,
    input logic [SPARE_W-1:0] spare_field,
    input logic               res_valid,
    input logic [VEC_W-1:0]   res_data,
    input logic               ud_fault
);
    logic legal;
    assign legal = (spare_field == {SPARE_W{1'b1}}) && (vlen_sel != 2'b11);

    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!res_valid && !ud_fault));
    a_r11_legal_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && legal) |=> (res_valid && !ud_fault));
    a_r9_spare_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && spare_field != {SPARE_W{1'b1}}) |=> (ud_fault && !res_valid));
    a_r10_rsv_len: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && vlen_sel == 2'b11) |=> ud_fault);
    a_r9_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
        ud_fault |-> $stable(res_data));
    a_r3_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && legal && vlen_sel == 2'b00) |=> (res_data[VEC_W-1:128] == '0));
    a_r6_zero_all: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && legal && mask_idx != 3'd0 && zero_mode && mask_bits == '0)
        |=> (res_data == '0));
endmodule

bind vbcast_unit vbcast_unit_chk u_chk (.*);

// File: tb/test_vbcast_unit.sv
module test_vbcast_unit;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [63:0]  scalar_in = '0;
    logic [1:0]   grain_sel = '0;
    logic         wide_sel = 1'b0;
    logic         long_mode = 1'b1;
    logic [1:0]   vlen_sel = '0;
    logic [2:0]   mask_idx = '0;
    logic [63:0]  mask_bits = '0;
    logic         zero_mode = 1'b0;
    logic [3:0]   spare_field = 4'hF;
    logic [511:0] old_dest = '0;
    logic         res_valid;
    logic [511:0] res_data;
    logic         ud_fault;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    vbcast_unit i_vbcast_unit (.*);

    task automatic chk(input bit ok, input string tag, input logic [511:0] act,
                       input logic [511:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [511:0] model(
        input logic [511:0] old, input logic [63:0] s, input logic [1:0] g,
        input logic w, input logic lm, input logic [1:0] vl, input logic [2:0] mi,
        input logic [63:0] m, input logic z);
        logic [511:0] r = '0;
        int ew = (g == 2'b00) ? 1 : (g == 2'b01) ? 2 : (w && lm) ? 8 : 4;
        int kl = (16 << vl) / ew;
        for (int j = 0; j < kl; j++) begin
            for (int k = 0; k < ew; k++) begin
                int p = j * ew + k;
                if (mi == 3'd0 || m[j]) r[p*8 +: 8] = s[k*8 +: 8];
                else if (z)             r[p*8 +: 8] = 8'h00;
                else                    r[p*8 +: 8] = old[p*8 +: 8];
            end
        end
        return r;
    endfunction

    // drive one request, sample one cycle later
    task automatic issue();
        @(negedge clk);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    function automatic logic [511:0] rnd512();
        logic [511:0] v;
        for (int i = 0; i < 16; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    initial begin
        #400000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [511:0] exp, prev;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(!res_valid && !ud_fault && res_data == '0, "R11 reset", res_data, '0);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(!res_valid && !ud_fault, "R11 idle", {510'd0, res_valid, ud_fault}, '0);

        // sweep
        for (int g = 0; g < 4; g++)
        for (int w = 0; w < 2; w++)
        for (int lm = 0; lm < 2; lm++)
        for (int vl = 0; vl < 3; vl++)
        for (int z = 0; z < 2; z++)
        for (int mk = 0; mk < 2; mk++) begin
            scalar_in = {$urandom, $urandom};
            old_dest  = rnd512();
            mask_bits = {$urandom, $urandom};
            grain_sel = 2'(g); wide_sel = 1'(w); long_mode = 1'(lm);
            vlen_sel = 2'(vl); zero_mode = 1'(z);
            mask_idx = (mk == 0) ? 3'd0 : 3'd5;
            spare_field = 4'hF;
            exp = model(old_dest, scalar_in, grain_sel, wide_sel, long_mode,
                        vlen_sel, mask_idx, mask_bits, zero_mode);
            issue();
            if (mk == 0)  chk(res_data == exp, "R4 nomask/R1 sizes", res_data, exp);
            else if (z)   chk(res_data == exp, "R6 zeroing", res_data, exp);
            else          chk(res_data == exp, "R5 merging", res_data, exp);
            chk(res_valid && !ud_fault, "R11 valid", {511'd0, res_valid}, 512'd1);
            chk(res_data >> (128 << vl) == '0, "R3 upper", res_data >> (128 << vl), '0);
        end

        // R1 byte broadcast, 512 bits, no mask
        scalar_in = 64'h1122_3344_5566_77A5; grain_sel = 0; vlen_sel = 2;
        mask_idx = 0; long_mode = 1; wide_sel = 0;
        issue();
        chk(res_data == {64{8'hA5}}, "R1 byte", res_data, {64{8'hA5}});
        // R2 256-bit word: 16 elements then zero
        grain_sel = 1; vlen_sel = 1;
        issue();
        exp = {256'd0, {16{16'h77A5}}};
        chk(res_data == exp, "R2 count", res_data, exp);
        // R8 wide ignored outside long mode
        grain_sel = 2; wide_sel = 1; long_mode = 0; vlen_sel = 2;
        issue();
        exp = {16{32'h5566_77A5}};
        chk(res_data == exp, "R8 dword", res_data, exp);
        long_mode = 1;
        issue();
        exp = {8{64'h1122_3344_5566_77A5}};
        chk(res_data == exp, "R1 quad", res_data, exp);
        // R7 high mask bits ignored: quad 512 has 8 elements
        old_dest = rnd512(); mask_idx = 3'd2; zero_mode = 0;
        mask_bits = 64'hFFFF_FFFF_FFFF_FF00;
        issue();
        chk(res_data == old_dest, "R7 high mask", res_data, old_dest);
        // R9 spare field fault
        prev = res_data;
        spare_field = 4'hE; scalar_in = 64'hDEAD_BEEF_0000_0001; mask_idx = 0;
        issue();
        chk(ud_fault && !res_valid, "R9 flag", {510'd0, ud_fault, res_valid}, 512'd2);
        chk(res_data == prev, "R9 hold", res_data, prev);
        // R10 reserved length
        spare_field = 4'hF; vlen_sel = 2'b11;
        issue();
        chk(ud_fault && !res_valid, "R10 flag", {510'd0, ud_fault, res_valid}, 512'd2);
        chk(res_data == prev, "R10 hold", res_data, prev);
        @(negedge clk);
        chk(!ud_fault && !res_valid, "R11 one-cycle", {510'd0, ud_fault, res_valid}, '0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule